// File: doc/BRIEF.md
# Dual-Access Debug Control Register Bank

This block holds the nine control registers that configure a processor's on-chip breakpoint logic. Two agents reach the same bank. The first is an external debugger. Its serial link has already been decoded into write-register and read-register requests, and each request carries a 4-bit register selector. The second is supervisor code on the processor, which writes the bank through a dedicated instruction path and can also read it back. The full contents of all nine registers are driven out continuously to the downstream breakpoint comparators.

Every register is seen as a 32-bit word. Bits that are not implemented store nothing and read as zero. Register 0 is the configuration/status word, and bit 6 of it is a write lock owned by the debugger. While the lock is set, processor writes to the eight breakpoint registers are discarded, and debugger writes still land. Software is meant to keep the two agents apart. If they do write in the same cycle, the debugger wins and a one-cycle collision flag reports the lost processor write.

Top module: `dbgRegBank`

## Requirements
- R1: After reset, all nine registers, both read-data outputs and the collision flag are zero, so the lock is clear.
- R2: A debugger write with selector 0 to 8 stores the write data into register `sel`, masked to its implemented bits. The new value is visible on `regFlat[32*sel +: 32]` after the clock edge that samples the write.
- R3: Registers 0 and 1 implement only bits [15:0]. Bits [31:16] of these two registers always read and output as zero. Registers 2 to 8 implement all 32 bits.
- R4: A read request on either side returns the selected register's value on that side's read-data output after the sampling edge. The value is taken before any write in the same cycle, and it holds until the next read request on that side.
- R5: Selectors 9 to 15 address nothing. Writes with them leave every register unchanged, and reads with them return zero.
- R6: A processor write with selector 1 to 8 stores masked data when bit 6 of register 0 is 0 and the debugger is not writing in the same cycle.
- R7: While bit 6 of register 0 is 1, processor writes to registers 1 to 8 leave them unchanged. Debugger writes to those registers still take effect.
- R8: A processor write to register 0 updates its implemented bits other than bit 6. Bit 6 keeps its value whatever the lock state, so only the debugger can set or clear it.
- R9: When both agents write in the same cycle, only the debugger write is applied. `collision` is 1 in the cycle after that edge and 0 after any edge without a double write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgWrEn | input | 1 | Debugger write request |
| dbgRdEn | input | 1 | Debugger read request |
| dbgSel | input | 4 | Debugger register selector |
| dbgWrData | input | 32 | Debugger write data |
| dbgRdData | output | 32 | Debugger read data |
| cpuWrEn | input | 1 | Processor write request |
| cpuRdEn | input | 1 | Processor read request |
| cpuSel | input | 4 | Processor register selector |
| cpuWrData | input | 32 | Processor write data |
| cpuRdData | output | 32 | Processor read data |
| collision | output | 1 | Same-cycle double write seen at the last edge |
| regFlat | output | 288 | All registers, register n at bits [32n+31:32n] |

## Verification
Each result becomes visible after a single register stage:
- Register contents change on `regFlat` right after the edge that samples the write.
- Read data shows up on the read outputs after the edge that samples the read request.
- `collision` reports the edge that just passed.

The bench applies every request just after a falling edge and holds it through one rising edge. It then compares all nine registers, both read outputs and the flag at the next falling edge. The expected values come from a model that is updated with the same one-edge latency. Read expectations are taken from the model before that cycle's write is applied.

// File: rtl/dbgRegPkg.sv
package dbgRegPkg;
  localparam int unsigned NUM_REGS    = 9;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned SEL_W       = 4;
  localparam int unsigned NARROW_REGS = 2;
  localparam int unsigned NARROW_W    = 16;
  localparam int unsigned CSR_SEL     = 0;
  localparam int unsigned LOCK_BIT    = 6;
  localparam int unsigned FLAT_W      = NUM_REGS * DATA_W;

  localparam logic [SEL_W-1:0]  LAST_SEL  = SEL_W'(NUM_REGS - 1);
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((64'd1 << NARROW_W) - 64'd1);

  // Write strobes from control to datapath
  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                fromDbg;
  } wrStrobe_t;

  function automatic logic [DATA_W-1:0] implMask(input int unsigned idx);
    return (idx < NARROW_REGS) ? NARROW_MASK : {DATA_W{1'b1}};
  endfunction
endpackage

// File: rtl/dbgRegCtrl.sv
module dbgRegCtrl
  import dbgRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dbgWrEn,
  input  logic [SEL_W-1:0] dbgSel,
  input  logic             cpuWrEn,
  input  logic [SEL_W-1:0] cpuSel,
  input  logic             lockNow,
  output wrStrobe_t        strobes,
  output logic             collision
);
  logic dbgHit;
  logic cpuHit;
  logic cpuTake;

  assign dbgHit  = dbgWrEn && (dbgSel <= LAST_SEL);
  assign cpuHit  = cpuWrEn && (cpuSel <= LAST_SEL);
  // debugger has priority; lock only guards breakpoint registers
  assign cpuTake = cpuHit && !dbgWrEn &&
                   ((cpuSel == SEL_W'(CSR_SEL)) || !lockNow);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign strobes.wrSel[i] = (dbgHit && (dbgSel == SEL_W'(i))) ||
                              (cpuTake && (cpuSel == SEL_W'(i)));
  end
  assign strobes.fromDbg = dbgWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) collision <= 1'b0;
    else       collision <= dbgWrEn && cpuWrEn;
  end
endmodule

// File: rtl/dbgRegData.sv
module dbgRegData
  import dbgRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobes,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              dbgRdEn,
  input  logic [SEL_W-1:0]  dbgSel,
  input  logic              cpuRdEn,
  input  logic [SEL_W-1:0]  cpuSel,
  output logic [DATA_W-1:0] dbgRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              lockNow,
  output logic [FLAT_W-1:0] regFlat
);
  logic [DATA_W-1:0] regs  [NUM_REGS];
  logic [DATA_W-1:0] wrVal [NUM_REGS];
  logic [DATA_W-1:0] wData;
  logic [DATA_W-1:0] dbgMux;
  logic [DATA_W-1:0] cpuMux;

  assign wData = strobes.fromDbg ? dbgWrData : cpuWrData;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == CSR_SEL) begin : g_csr
      // processor cannot move the lock bit
      assign wrVal[i] = strobes.fromDbg ? (wData & implMask(i))
                      : ((wData & implMask(i) & ~LOCK_MASK) | (regs[i] & LOCK_MASK));
    end else begin : g_bp
      assign wrVal[i] = wData & implMask(i);
    end
    assign regFlat[i*DATA_W +: DATA_W] = regs[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN)                 regs[i] <= '0;
      else if (strobes.wrSel[i]) regs[i] <= wrVal[i];
    end
  end

  always_comb begin
    dbgMux = '0;
    cpuMux = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (dbgSel == SEL_W'(i)) dbgMux = regs[i];
      if (cpuSel == SEL_W'(i)) cpuMux = regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgRdData <= '0;
      cpuRdData <= '0;
    end else begin
      if (dbgRdEn) dbgRdData <= dbgMux;
      if (cpuRdEn) cpuRdData <= cpuMux;
    end
  end

  assign lockNow = regs[CSR_SEL][LOCK_BIT];
endmodule

// File: rtl/dbgRegBank.sv
module dbgRegBank
  import dbgRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgWrEn,
  input  logic              dbgRdEn,
  input  logic [SEL_W-1:0]  dbgSel,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgRdData,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic [SEL_W-1:0]  cpuSel,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              collision,
  output logic [FLAT_W-1:0] regFlat
);
  wrStrobe_t strobes;
  logic      lockNow;

  dbgRegCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .dbgWrEn(dbgWrEn), .dbgSel(dbgSel),
    .cpuWrEn(cpuWrEn), .cpuSel(cpuSel),
    .lockNow(lockNow), .strobes(strobes), .collision(collision)
  );

  dbgRegData u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dbgWrData(dbgWrData), .cpuWrData(cpuWrData),
    .dbgRdEn(dbgRdEn), .dbgSel(dbgSel),
    .cpuRdEn(cpuRdEn), .cpuSel(cpuSel),
    .dbgRdData(dbgRdData), .cpuRdData(cpuRdData),
    .lockNow(lockNow), .regFlat(regFlat)
  );
endmodule

// File: rtl/dbgRegBankChk.sv
module dbgRegBankChk
  import dbgRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dbgWrEn,
  input logic              dbgRdEn,
  input logic [SEL_W-1:0]  dbgSel,
  input logic [DATA_W-1:0] dbgWrData,
  input logic [DATA_W-1:0] dbgRdData,
  input logic              cpuWrEn,
  input logic              cpuRdEn,
  input logic [SEL_W-1:0]  cpuSel,
  input logic [DATA_W-1:0] cpuWrData,
  input logic [DATA_W-1:0] cpuRdData,
  input logic              collision,
  input logic [FLAT_W-1:0] regFlat
);
  logic lockBit;
  assign lockBit = regFlat[CSR_SEL*DATA_W + LOCK_BIT];

  // R9
  collision_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWrEn && cpuWrEn) |=> collision);
  // R9
  collision_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dbgWrEn && cpuWrEn) |=> !collision);
  // R7
  lock_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockBit && cpuWrEn && !dbgWrEn) |=> $stable(regFlat[FLAT_W-1:DATA_W]));
  // R8
  lock_bit_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !dbgWrEn) |=> $stable(regFlat[CSR_SEL*DATA_W + LOCK_BIT]));
  // R5
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWrEn && (dbgSel > LAST_SEL) && !cpuWrEn) |=> $stable(regFlat));
  // R5
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgRdEn && (dbgSel > LAST_SEL)) |=> (dbgRdData == '0));
  // R3
  narrow_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regFlat[DATA_W-1:NARROW_W] == '0) && (regFlat[2*DATA_W-1:DATA_W+NARROW_W] == '0));
endmodule

bind dbgRegBank dbgRegBankChk u_chk (.*);

// File: tb/test_dbgRegBank.sv
module test_dbgRegBank;
  import dbgRegPkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              dbgWrEn, dbgRdEn, cpuWrEn, cpuRdEn;
  logic [SEL_W-1:0]  dbgSel, cpuSel;
  logic [DATA_W-1:0] dbgWrData, cpuWrData, dbgRdData, cpuRdData;
  logic              collision;
  logic [FLAT_W-1:0] regFlat;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model [NUM_REGS];
  logic [31:0] expDbgRd, expCpuRd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgRegBank i_dbgRegBank (
    .clk(clk), .rstN(rstN),
    .dbgWrEn(dbgWrEn), .dbgRdEn(dbgRdEn), .dbgSel(dbgSel),
    .dbgWrData(dbgWrData), .dbgRdData(dbgRdData),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuSel(cpuSel),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .collision(collision), .regFlat(regFlat)
  );

  function automatic logic [31:0] maskOf(input int idx);
    return (idx < 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] readModel(input logic [3:0] s);
    return (s <= 4'd8) ? model[s] : 32'h0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chkAll(input string tag, input logic expCol);
    for (int i = 0; i < NUM_REGS; i++)
      chk(tag, $sformatf("reg%0d", i), regFlat[i*32 +: 32], model[i]);
    chk("R4", "dbgRdData", dbgRdData, expDbgRd);
    chk("R4", "cpuRdData", cpuRdData, expCpuRd);
    chk("R9", "collision", {31'b0, collision}, {31'b0, expCol});
  endtask

  task automatic step(input logic dW, input logic dR, input logic [3:0] dS, input logic [31:0] dD,
                      input logic cW, input logic cR, input logic [3:0] cS, input logic [31:0] cD);
    string tag;
    logic lock;
    lock = model[0][6];
    if (dW && cW)      tag = "R9";
    else if (dW)       tag = (dS > 4'd8) ? "R5" : "R2";
    else if (cW)       tag = (cS > 4'd8) ? "R5" : (cS == 4'd0) ? "R8" : lock ? "R7" : "R6";
    else               tag = "R4";
    dbgWrEn = dW; dbgRdEn = dR; dbgSel = dS; dbgWrData = dD;
    cpuWrEn = cW; cpuRdEn = cR; cpuSel = cS; cpuWrData = cD;
    if (dR) expDbgRd = readModel(dS);
    if (cR) expCpuRd = readModel(cS);
    if (dW) begin
      if (dS <= 4'd8) model[dS] = dD & maskOf(int'(dS));
    end else if (cW && cS <= 4'd8) begin
      if (cS == 4'd0)
        model[0] = (cD & maskOf(0) & ~32'h40) | (model[0] & 32'h40);
      else if (!lock)
        model[cS] = cD & maskOf(int'(cS));
    end
    @(posedge clk);
    @(negedge clk);
    dbgWrEn = 0; dbgRdEn = 0; cpuWrEn = 0; cpuRdEn = 0;
    chkAll(tag, dW && cW);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_REGS; i++) model[i] = 32'h0;
    expDbgRd = 0; expCpuRd = 0;
    rstN = 0; dbgWrEn = 0; dbgRdEn = 0; cpuWrEn = 0; cpuRdEn = 0;
    dbgSel = 0; cpuSel = 0; dbgWrData = 0; cpuWrData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    chkAll("R1", 1'b0);

    // R3 narrow registers drop upper bits
    step(1, 0, 4'd1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 0, 4'd0, 32'hABCD_1234 & ~32'h40, 0, 0, 0, 0);
    // R2 / R4 wide write and read back on both sides
    step(1, 0, 4'd5, 32'hA5A5_5A5A, 0, 0, 0, 0);
    step(0, 1, 4'd5, 0, 0, 1, 4'd1, 0);
    // R5 unmapped write and read
    step(1, 0, 4'd11, 32'hDEAD_BEEF, 0, 1, 4'd11, 0);
    step(0, 1, 4'd15, 0, 0, 0, 0, 0);
    // R6 processor write with lock clear
    step(0, 0, 0, 0, 1, 0, 4'd3, 32'h1234_5678);
    // R7 set lock, processor blocked, debugger still writes
    step(1, 0, 4'd0, 32'h0000_0040, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 4'd3, 32'hFFFF_0000);
    step(0, 0, 0, 0, 1, 0, 4'd8, 32'h0F0F_0F0F);
    step(1, 0, 4'd3, 32'h0BAD_CAFE, 0, 0, 0, 0);
    // R8 processor cannot clear or set the lock bit
    step(0, 0, 0, 0, 1, 0, 4'd0, 32'h0000_1200);
    step(1, 0, 4'd0, 32'h0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 4'd0, 32'hFFFF_FFFF);
    // R9 collision: debugger wins
    step(1, 0, 4'd7, 32'h7777_0000, 1, 0, 4'd7, 32'h0000_9999);
    step(1, 0, 4'd2, 32'h2222_2222, 1, 0, 4'd6, 32'h6666_6666);

    for (int n = 0; n < 600; n++) begin
      logic dW, cW;
      logic [3:0] dS;
      dW = ($urandom % 10) < 3;
      cW = ($urandom % 10) < 4;
      dS = 4'($urandom % 16);
      // bias debugger toward the lock word
      if (($urandom % 4) == 0) dS = 4'd0;
      step(dW, 1'($urandom), dS, $urandom, cW, 1'($urandom), 4'($urandom % 16), $urandom);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule